// File: doc/BRIEF.md
# Receive Character Queue with Line Status Flags

This block sits between a serial receiver's shift register and the CPU. Each time the receiver has assembled a whole character, it pulses a strobe with the eight data bits and two error bits: a parity error and a framing error. A framing error means the bit after the last data or parity bit was sampled as spacing (0). The block keeps these characters in order and shows the oldest one at its head. It also derives four status flags for the CPU: data ready, overrun, parity error and framing error.

The block has two modes. In queue mode it holds up to `DEPTH` characters, 16 by default. In single-register mode it holds one character, and a new arrival replaces an unread one. The error bits travel with their character. They show in the status flags only once that character has reached the head. The CPU clears the overrun, parity and framing flags by reading the status. A clear input empties the queue and drops all flags. Bit-level sampling, start-bit resynchronisation and baud timing belong to the receiver and are outside this block.

Top module: `rx_char_queue`

## Requirements
- R1: After reset, `st_ready`, `st_overrun`, `st_parity`, `st_framing` and `queue_full` are all 0.
- R2: `st_ready` goes to 1 in the cycle after a character is stored. It stays 1 until the read strobe removes the last stored character and drops in the cycle after that read.
- R3: In queue mode (`fifo_mode`=1), characters leave in arrival order, and `head_data` always shows the oldest stored character.
- R4: `queue_full` is 1 exactly when the stored count equals the capacity. The capacity is `DEPTH` in queue mode and 1 in single-register mode (`fifo_mode`=0).
- R5: In queue mode, a character that arrives while the queue is full, with no read in the same cycle, is discarded. The stored characters are kept, and `st_overrun` is 1 from the next cycle.
- R6: In single-register mode, a character that arrives while an unread one is held replaces it at `head_data`, and `st_overrun` is 1 from the next cycle.
- R7: A status read (`rd_status_stb`) clears `st_overrun` in the next cycle. If an overrun happens in the same cycle as the status read, the flag stays 1.
- R8: The parity and framing bits are stored with each character. A set bit raises `st_parity` / `st_framing` one cycle after its character reaches the head. An error on a character behind the head is not shown.
- R9: A status read clears `st_parity` and `st_framing` in the next cycle, and they stay clear while the same character remains at the head. If a fresh head error is latched in the same cycle as the status read, that flag stays 1.
- R10: `fifo_clear` empties the queue and clears all four flags in the next cycle. A character that arrives in the same cycle is not stored.
- R11: A change of `fifo_mode` empties the queue and clears the flags, in the same way as `fifo_clear`.
- R12: A read strobe while the queue is empty changes nothing. At capacity, a read and an arrival in the same cycle store the new character without an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode | input | 1 | 1 = queue of DEPTH entries, 0 = single register |
| fifo_clear | input | 1 | Empties the queue and clears all flags |
| char_valid | input | 1 | One-cycle strobe: a complete character is offered |
| char_data | input | 8 | Received character |
| char_perr | input | 1 | Parity error for this character |
| char_ferr | input | 1 | Framing error (stop bit sampled as 0) |
| rd_data_stb | input | 1 | CPU read of the receive buffer; removes the head |
| rd_status_stb | input | 1 | CPU read of the status; clears the sticky flags |
| head_data | output | 8 | Oldest stored character (0 while empty) |
| st_ready | output | 1 | At least one character is stored |
| st_overrun | output | 1 | Sticky overrun flag |
| st_parity | output | 1 | Sticky parity-error flag |
| st_framing | output | 1 | Sticky framing-error flag |
| queue_full | output | 1 | Stored count equals the capacity of the current mode |

## Verification
The embedded assertions check the following on every cycle:
- the stored count never exceeds the capacity;
- a stored character raises data ready in the next cycle;
- an overrun event sets the overrun flag and, in queue mode, leaves the count unchanged;
- an overwrite in single-register mode puts the new byte at the head;
- a clear drops every flag.

Some behaviours depend on the order of several events, so only the bench's scenarios can show them:
- that characters leave in arrival order;
- that a discarded character never reappears;
- that an error bit shows only once its character is at the head;
- that a status read loses against an event in the same cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int unsigned CHAR_W = 8;

    // One stored character with the error bits that travel with it
    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rxq_entry_t;

    // Sticky flags presented to the CPU
    typedef struct packed {
        logic framing;
        logic parity;
        logic overrun;
    } rxq_sticky_t;

    // Ring index increment for a depth that need not be a power of two
    function automatic int unsigned ring_next(int unsigned idx, int unsigned depth);
        return (idx + 1 >= depth) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic          ovw,
    input  rxq_entry_t    wr_entry,
    output rxq_entry_t    head_entry,
    output logic [CW-1:0] count
);

    rxq_entry_t    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (ovw) begin
                mem[rd_ptr] <= wr_entry;
            end else begin
                if (push) begin
                    mem[wr_ptr] <= wr_entry;
                    wr_ptr <= AW'(ring_next(int'(wr_ptr), DEPTH));
                end
                if (pop) begin
                    rd_ptr <= AW'(ring_next(int'(rd_ptr), DEPTH));
                end
                case ({push, pop})
                    2'b10:   count <= count + 1'b1;
                    2'b01:   count <= count - 1'b1;
                    default: count <= count;
                endcase
            end
        end
    end

    assign head_entry = (count != '0) ? mem[rd_ptr] : '0;

    // R4
    count_in_cap_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R2
    push_grows_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !flush && !ovw) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
    import rxq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic        head_valid,
    input  logic        head_change,
    input  logic        head_perr,
    input  logic        head_ferr,
    input  logic        ovr_event,
    input  logic        status_rd,
    output rxq_sticky_t sticky
);

    logic head_seen;
    logic head_fresh;

    // Errors of a character are latched once, in the cycle after it reaches the head
    assign head_fresh = head_valid && !head_seen;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            sticky    <= '0;
            head_seen <= 1'b0;
        end else begin
            sticky.overrun <= ovr_event || (sticky.overrun && !status_rd);
            sticky.parity  <= (head_fresh && head_perr) || (sticky.parity && !status_rd);
            sticky.framing <= (head_fresh && head_ferr) || (sticky.framing && !status_rd);
            head_seen      <= head_change ? 1'b0 : head_valid;
        end
    end

    // R5
    ovr_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr_event && !flush) |=> sticky.overrun);

    // R7
    ovr_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !ovr_event) |=> !sticky.overrun);

    // R10
    flush_drops_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (sticky == '0));

endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_mode,
    input  logic              fifo_clear,
    input  logic              char_valid,
    input  logic [CHAR_W-1:0] char_data,
    input  logic              char_perr,
    input  logic              char_ferr,
    input  logic              rd_data_stb,
    input  logic              rd_status_stb,
    output logic [CHAR_W-1:0] head_data,
    output logic              st_ready,
    output logic              st_overrun,
    output logic              st_parity,
    output logic              st_framing,
    output logic              queue_full
);

    logic          mode_q;
    logic          flush;
    logic [CW-1:0] count;
    logic [CW-1:0] cap;
    logic          at_cap;
    logic          accept;
    logic          do_pop;
    logic          do_push;
    logic          do_ovw;
    logic          ovr_event;
    rxq_entry_t    wr_entry;
    rxq_entry_t    head_entry;
    rxq_sticky_t   sticky;

    // A mode switch empties the queue, as an explicit clear does
    always_ff @(posedge clk) begin
        if (rst) mode_q <= fifo_mode;
        else     mode_q <= fifo_mode;
    end

    assign flush     = fifo_clear || (fifo_mode != mode_q);
    assign cap       = fifo_mode ? CW'(DEPTH) : CW'(1);
    assign at_cap    = (count >= cap);
    assign accept    = char_valid && !flush;
    assign do_pop    = rd_data_stb && (count != '0) && !flush;
    assign do_push   = accept && (!at_cap || do_pop);
    assign ovr_event = accept && at_cap && !do_pop;
    assign do_ovw    = ovr_event && !fifo_mode;

    assign wr_entry = '{data: char_data, perr: char_perr, ferr: char_ferr};

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .push       (do_push),
        .pop        (do_pop),
        .ovw        (do_ovw),
        .wr_entry   (wr_entry),
        .head_entry (head_entry),
        .count      (count)
    );

    rxq_flags u_flags (
        .clk         (clk),
        .rst         (rst),
        .flush       (flush),
        .head_valid  (count != '0),
        .head_change (do_pop || do_ovw),
        .head_perr   (head_entry.perr),
        .head_ferr   (head_entry.ferr),
        .ovr_event   (ovr_event),
        .status_rd   (rd_status_stb),
        .sticky      (sticky)
    );

    assign head_data  = head_entry.data;
    assign st_ready   = (count != '0);
    assign st_overrun = sticky.overrun;
    assign st_parity  = sticky.parity;
    assign st_framing = sticky.framing;
    assign queue_full = (count == cap);

    // R2
    ready_after_store_chk: assert property (@(posedge clk) disable iff (rst)
        (do_push && !flush) |=> st_ready);

    // R5
    full_keeps_count_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_mode && ovr_event && fifo_mode == mode_q && !fifo_clear) |=> $stable(count));

    // R6
    overwrite_head_chk: assert property (@(posedge clk) disable iff (rst)
        do_ovw |=> (head_data == $past(char_data)));

    // R12
    empty_read_noop_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data_stb && !st_ready && !char_valid) |=> !st_ready);

endmodule

// File: tb/test_rx_char_queue.sv
module test_rx_char_queue;

    logic       clk = 1'b0;
    logic       rst;
    logic       fifo_mode;
    logic       fifo_clear;
    logic       char_valid;
    logic [7:0] char_data;
    logic       char_perr;
    logic       char_ferr;
    logic       rd_data_stb;
    logic       rd_status_stb;
    logic [7:0] head_data;
    logic       st_ready;
    logic       st_overrun;
    logic       st_parity;
    logic       st_framing;
    logic       queue_full;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    rx_char_queue #(.DEPTH(16)) i_rx_char_queue (
        .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .fifo_clear(fifo_clear),
        .char_valid(char_valid), .char_data(char_data), .char_perr(char_perr),
        .char_ferr(char_ferr), .rd_data_stb(rd_data_stb), .rd_status_stb(rd_status_stb),
        .head_data(head_data), .st_ready(st_ready), .st_overrun(st_overrun),
        .st_parity(st_parity), .st_framing(st_framing), .queue_full(queue_full)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // One cycle of stimulus, driven at a falling edge; returns after the rising edge
    task automatic cyc(bit v, logic [7:0] d, bit pe, bit fe, bit rdd, bit rds, bit clr);
        char_valid = v; char_data = d; char_perr = pe; char_ferr = fe;
        rd_data_stb = rdd; rd_status_stb = rds; fifo_clear = clr;
        @(negedge clk);
        char_valid = 0; char_data = '0; char_perr = 0; char_ferr = 0;
        rd_data_stb = 0; rd_status_stb = 0; fifo_clear = 0;
    endtask

    task automatic send(logic [7:0] d, bit pe = 0, bit fe = 0);
        cyc(1, d, pe, fe, 0, 0, 0);
    endtask

    task automatic clear_all();
        cyc(0, 0, 0, 0, 0, 0, 1);
    endtask

    task automatic t_reset();
        check("R1 ready", st_ready, 0);
        check("R1 overrun", st_overrun, 0);
        check("R1 parity", st_parity, 0);
        check("R1 framing", st_framing, 0);
        check("R1 full", queue_full, 0);
    endtask

    task automatic t_order();
        clear_all();
        send(8'hA1); check("R2 ready after store", st_ready, 1);
        send(8'hB2); send(8'hC3);
        check("R3 head oldest", head_data, 8'hA1);
        cyc(0, 0, 0, 0, 1, 0, 0); check("R3 second", head_data, 8'hB2);
        cyc(0, 0, 0, 0, 1, 0, 0); check("R3 third", head_data, 8'hC3);
        check("R2 ready held", st_ready, 1);
        cyc(0, 0, 0, 0, 1, 0, 0); check("R2 ready drops", st_ready, 0);
    endtask

    task automatic t_full_overrun();
        clear_all();
        for (int i = 0; i < 16; i++) send(8'(i * 7 + 3));
        check("R4 full at depth", queue_full, 1);
        check("R5 no overrun yet", st_overrun, 0);
        send(8'hEE);
        check("R5 overrun set", st_overrun, 1);
        check("R5 still full", queue_full, 1);
        for (int i = 0; i < 16; i++) begin
            check("R5 kept data", head_data, 8'(i * 7 + 3));
            cyc(0, 0, 0, 0, 1, 0, 0);
        end
        check("R5 extra discarded", st_ready, 0);
        cyc(0, 0, 0, 0, 0, 1, 0);
        check("R7 overrun cleared", st_overrun, 0);
    endtask

    task automatic t_single();
        fifo_mode = 0; step(1);
        check("R11 mode switch empties", st_ready, 0);
        send(8'h11);
        check("R4 full at one", queue_full, 1);
        send(8'h22);
        check("R6 overrun", st_overrun, 1);
        check("R6 replaced", head_data, 8'h22);
        cyc(1, 8'h33, 0, 0, 0, 1, 0);
        check("R7 event wins", st_overrun, 1);
        check("R6 replaced again", head_data, 8'h33);
        cyc(0, 0, 0, 0, 0, 1, 0);
        check("R7 cleared", st_overrun, 0);
        cyc(1, 8'h44, 0, 0, 1, 0, 0);
        check("R12 read+arrive no overrun", st_overrun, 0);
        check("R12 new head", head_data, 8'h44);
        check("R12 ready", st_ready, 1);
        send(8'h55);
        fifo_mode = 1; step(1);
        check("R11 ready cleared", st_ready, 0);
        check("R11 overrun cleared", st_overrun, 0);
    endtask

    task automatic t_errors();
        clear_all();
        send(8'h41); send(8'h42, 1, 0); send(8'h43, 0, 1); send(8'h44, 0, 1);
        step(1);
        check("R8 hidden parity", st_parity, 0);
        check("R8 hidden framing", st_framing, 0);
        cyc(0, 0, 0, 0, 1, 0, 0); step(1);
        check("R8 parity at head", st_parity, 1);
        check("R8 framing clean", st_framing, 0);
        cyc(0, 0, 0, 0, 0, 1, 0);
        check("R9 parity cleared", st_parity, 0);
        step(2);
        check("R9 stays clear", st_parity, 0);
        cyc(0, 0, 0, 0, 1, 0, 0); step(1);
        check("R8 framing at head", st_framing, 1);
        cyc(0, 0, 0, 0, 0, 1, 0);
        check("R9 framing cleared", st_framing, 0);
        cyc(0, 0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 0);
        check("R9 event wins", st_framing, 1);
        cyc(0, 0, 0, 0, 0, 1, 0);
        check("R9 later clear", st_framing, 0);
    endtask

    task automatic t_clear();
        clear_all();
        send(8'h61, 1, 0); send(8'h62); step(1);
        check("R10 setup parity", st_parity, 1);
        cyc(1, 8'h63, 0, 0, 0, 0, 1);
        check("R10 emptied", st_ready, 0);
        check("R10 parity cleared", st_parity, 0);
        check("R10 not full", queue_full, 0);
        step(1);
        check("R10 arrival dropped", st_ready, 0);
    endtask

    task automatic t_empty_read();
        clear_all();
        cyc(0, 0, 0, 0, 1, 0, 0);
        check("R12 empty read", st_ready, 0);
        send(8'h5A);
        check("R12 head after empty read", head_data, 8'h5A);
        check("R12 overrun idle", st_overrun, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; fifo_mode = 1; fifo_clear = 0; char_valid = 0; char_data = '0;
        char_perr = 0; char_ferr = 0; rd_data_stb = 0; rd_status_stb = 0;
        step(3);
        rst = 0;
        step(1);
        t_reset();
        t_order();
        t_full_overrun();
        t_single();
        t_errors();
        t_clear();
        t_empty_read();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule